// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the handshake engine of a PCI-style bus target. An address decoder outside the block raises a hit flag during the address phase. The controller then claims the transaction by driving DEVSEL# low after a fixed decode latency. It paces each data beat with TRDY# according to a local "ready" signal. It also gives the local side a one-clock strobe for every beat that actually moves on the bus.

When the local side asks to stop, the controller ends the transaction from the target side by raising STOP#. It picks one of three endings. If data is ready and IRDY# is already low, the last beat transfers at once. If data is ready but the initiator is not, TRDY# is held until IRDY# arrives. If no data is ready, STOP# is driven with TRDY# high, which is a retry. The controller keeps STOP# asserted until the initiator drops FRAME#. It then releases all three handshake lines on one edge. It answers nothing more until the bus has shown an idle cycle.

All bus signals are active low. The controller samples them on the rising edge of `clk` and drives its outputs from registers.

Top module: `pci_target_term`

## Requirements
- R1: While `rstN` is low, `devselN`, `trdyN` and `stopN` are high and `xferStrobe` is low; a reset in the middle of a transaction returns them to that state without waiting for a clock.
- R2: When the controller is idle and samples `frameN` low with `addrHit` high, `devselN` goes low exactly `DECODE_LAT` rising edges later. `frameN` low with `addrHit` low draws no response.
- R3: `xferStrobe` is high exactly on clocks where `trdyN` and `irdyN` are both low, and only while the target is selected.
- R4: Once `trdyN` is low, it stays low until an edge at which `irdyN` is also low. This holds whatever `localReady` does in the meantime.
- R5: If `localStop` and `localReady` are both high at a decision edge, `stopN` and `trdyN` go low together on that edge. The pending beat then completes on the first edge with `irdyN` low: at once if the initiator is ready, later if it is not.
- R6: If `localStop` is high and `localReady` is low at a decision edge, with no beat pending, `stopN` goes low with `trdyN` high. `trdyN` then stays high for the rest of the transaction (retry).
- R7: Once `stopN` is low, it stays low on every edge at which `frameN` is still low.
- R8: The transaction ends at the first edge where `frameN` is high and no beat is left waiting, meaning `trdyN` is high or `irdyN` is low. On that edge `devselN`, `trdyN` and `stopN` all go high together.
- R9: After a transaction ends or is ignored, the controller does not respond to `frameN` until it has sampled `frameN` and `irdyN` both high on one edge.
- R10: In the data phase without a stop request, the controller sets `trdyN` for the next edge from `localReady` whenever no beat is pending. An initiator ends the burst normally by completing a beat with `frameN` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Initiator cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| addrHit | input | 1 | Address decoder hit, valid in the address phase |
| localReady | input | 1 | Local side can move the next beat |
| localStop | input | 1 | Local side requests target termination |
| devselN | output | 1 | Device select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Target stop request, active low |
| xferStrobe | output | 1 | One-clock pulse per completed data beat |

## Verification
The hardest case to reach is the waiting disconnect. In that case STOP# and TRDY# are both low while IRDY# stays high, and FRAME# has already risen. The controller must then hold everything, neither releasing nor transferring, until IRDY# falls. The stimulus table reaches it by raising the stop and ready requests on the very edge where the decode latency expires. It keeps IRDY# high for two further clocks while FRAME# is already deasserted. Straight after that ending, the table drops FRAME# again without an idle cycle, to show that the controller stays silent until it sees one.

// File: rtl/pci_tt_pkg.sv
package pci_tt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_TERM,
    ST_DRAIN
  } tgtState_t;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setSel;
    logic setTrdy;
    logic clrTrdy;
    logic setStop;
    logic releaseAll;
  } tgtCmd_t;

  // Status returned by the datapath
  typedef struct packed {
    logic cntZero;
    logic trdyOn;
  } tgtStat_t;

endpackage

// File: rtl/pci_tt_dp.sv
module pci_tt_dp
  import pci_tt_pkg::*;
#(
  parameter int CNT_W    = 2,
  parameter int LAT_INIT = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  tgtCmd_t  cmd,
  input  logic     irdyOn,
  output tgtStat_t stat,
  output logic     selOn,
  output logic     trdyOn,
  output logic     stopOn,
  output logic     xfer
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT_INIT);

  logic [CNT_W-1:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (cmd.loadCnt) begin
      latCnt <= CNT_LOAD;
    end else if (cmd.decCnt && latCnt != '0) begin
      latCnt <= latCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selOn  <= 1'b0;
      trdyOn <= 1'b0;
      stopOn <= 1'b0;
    end else if (cmd.releaseAll) begin
      selOn  <= 1'b0;
      trdyOn <= 1'b0;
      stopOn <= 1'b0;
    end else begin
      if (cmd.setSel)       selOn  <= 1'b1;
      if (cmd.setTrdy)      trdyOn <= 1'b1;
      else if (cmd.clrTrdy) trdyOn <= 1'b0;
      if (cmd.setStop)      stopOn <= 1'b1;
    end
  end

  assign xfer         = selOn && trdyOn && irdyOn;
  assign stat.cntZero = (latCnt == '0);
  assign stat.trdyOn  = trdyOn;

endmodule

// File: rtl/pci_tt_ctrl.sv
module pci_tt_ctrl
  import pci_tt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameOn,
  input  logic     irdyOn,
  input  logic     addrHit,
  input  logic     localReady,
  input  logic     localStop,
  input  tgtStat_t stat,
  output tgtCmd_t  cmd
);

  tgtState_t state, nextState;
  tgtCmd_t   stepCmd;
  logic      pending, beat;

  assign beat    = stat.trdyOn && irdyOn;
  assign pending = stat.trdyOn && !irdyOn;

  // Per-beat decision shared by the first data edge and the data phase
  always_comb begin
    stepCmd = '0;
    if (localStop) stepCmd.setStop = 1'b1;
    if (!pending) begin
      if (localReady) stepCmd.setTrdy = 1'b1;
      else            stepCmd.clrTrdy = 1'b1;
    end
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (frameOn) begin
          if (addrHit) begin
            cmd.loadCnt = 1'b1;
            nextState   = ST_DECODE;
          end else begin
            nextState = ST_DRAIN;
          end
        end
      end
      ST_DECODE: begin
        if (stat.cntZero) begin
          cmd        = stepCmd;
          cmd.setSel = 1'b1;
          nextState  = localStop ? ST_TERM : ST_DATA;
        end else begin
          cmd.decCnt = 1'b1;
        end
      end
      ST_DATA: begin
        if (!frameOn && beat) begin
          cmd.releaseAll = 1'b1;
          nextState      = ST_DRAIN;
        end else begin
          cmd       = stepCmd;
          nextState = localStop ? ST_TERM : ST_DATA;
        end
      end
      ST_TERM: begin
        if (!frameOn && !pending) begin
          cmd.releaseAll = 1'b1;
          nextState      = ST_DRAIN;
        end else if (beat) begin
          cmd.clrTrdy = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!frameOn && !irdyOn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/pci_target_term.sv
module pci_target_term
  import pci_tt_pkg::*;
#(
  parameter int DECODE_LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameN,
  input  logic irdyN,
  input  logic addrHit,
  input  logic localReady,
  input  logic localStop,
  output logic devselN,
  output logic trdyN,
  output logic stopN,
  output logic xferStrobe
);

  localparam int CNT_W    = $clog2(DECODE_LAT + 1);
  localparam int LAT_INIT = (DECODE_LAT > 0) ? DECODE_LAT - 1 : 0;

  tgtCmd_t  cmd;
  tgtStat_t stat;
  logic     selOn, trdyOn, stopOn, xfer;

  pci_tt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameOn    (!frameN),
    .irdyOn     (!irdyN),
    .addrHit    (addrHit),
    .localReady (localReady),
    .localStop  (localStop),
    .stat       (stat),
    .cmd        (cmd)
  );

  pci_tt_dp #(
    .CNT_W    (CNT_W),
    .LAT_INIT (LAT_INIT)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .irdyOn (!irdyN),
    .stat   (stat),
    .selOn  (selOn),
    .trdyOn (trdyOn),
    .stopOn (stopOn),
    .xfer   (xfer)
  );

  assign devselN    = !selOn;
  assign trdyN      = !trdyOn;
  assign stopN      = !stopOn;
  assign xferStrobe = xfer;

endmodule

// File: rtl/pci_target_term_chk.sv
module pci_target_term_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic irdyN,
  input logic devselN,
  input logic trdyN,
  input logic stopN,
  input logic xferStrobe
);

  // R1: reset holds the bus handshake released
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |-> (devselN && trdyN && stopN && !xferStrobe));

  // R3: a beat strobe only with both readies and a selected target
  a_r3_strobe_beat: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobe |-> (!irdyN && !trdyN && !devselN));

  // R2: target ready and stop never appear without device select
  a_r2_sel_cover: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN || !stopN) |-> !devselN);

  // R4: target ready held until initiator ready arrives
  a_r4_trdy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN) |=> !trdyN);

  // R6: after a retry no target ready returns
  a_r6_retry_nodata: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && trdyN) |=> trdyN);

  // R7: stop held while frame remains asserted
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> !stopN);

  // R8: all handshake lines released on one edge
  a_r8_release_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devselN) |-> (trdyN && stopN));

endmodule

bind pci_target_term pci_target_term_chk i_chk (.*);

// File: tb/test_pci_target_term.sv
module test_pci_target_term;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, addrHit = 1'b0;
  logic localReady = 1'b0, localStop = 1'b0;
  logic devselN, trdyN, stopN, xferStrobe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pci_target_term #(.DECODE_LAT(2)) i_pci_target_term (
    .clk        (clk),
    .rstN       (rstN),
    .frameN     (frameN),
    .irdyN      (irdyN),
    .addrHit    (addrHit),
    .localReady (localReady),
    .localStop  (localStop),
    .devselN    (devselN),
    .trdyN      (trdyN),
    .stopN      (stopN),
    .xferStrobe (xferStrobe)
  );

  // Row: {frameN, irdyN, addrHit, localReady, localStop, devselN, trdyN, stopN, xferStrobe}
  // Expected outputs are those seen after driving the row, before its edge.
  localparam int NV = 35;
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b11000_1110, // 0  R1 idle after reset
    9'b01110_1110, // 1  R2 address phase, hit
    9'b00010_1110, // 2  R2 latency counting
    9'b00010_1110, // 3  R2 latency counting
    9'b00010_0011, // 4  R3 beat 1
    9'b00011_0011, // 5  R3 beat 2, stop requested
    9'b10000_0001, // 6  R5 stop with data, beat transfers
    9'b11000_1110, // 7  R8 released together
    9'b01100_1110, // 8  R2 new transaction
    9'b01000_1110, // 9  R2 latency
    9'b01011_1110, // 10 R2 stop+ready at first decision
    9'b11000_0000, // 11 R5 waiting disconnect, no irdy
    9'b11000_0000, // 12 R4 trdy held
    9'b10000_0001, // 13 R5 final beat when irdy arrives
    9'b01100_1110, // 14 R9 frame without idle ignored
    9'b01100_1110, // 15 R9 still ignored
    9'b11000_1110, // 16 R9 idle cycle
    9'b11000_1110, // 17 R9 idle
    9'b01100_1110, // 18 R2 third transaction
    9'b00000_1110, // 19 R2 latency
    9'b00001_1110, // 20 R6 stop without ready
    9'b00010_0100, // 21 R6 retry: stop, no trdy
    9'b10010_0100, // 22 R7 stop held while frame low
    9'b11000_1110, // 23 R8 release on frame high
    9'b01000_1110, // 24 R2 miss
    9'b00100_1110, // 25 R9 miss ignored until idle
    9'b11000_1110, // 26 R9 idle
    9'b01100_1110, // 27 R2 fourth transaction
    9'b01000_1110, // 28 R2 latency
    9'b01010_1110, // 29 R10 ready at first decision
    9'b01000_0010, // 30 R4 trdy held, not ready ignored
    9'b00000_0011, // 31 R3 beat
    9'b00010_0110, // 32 R10 trdy follows not ready
    9'b10010_0011, // 33 R10 final beat with frame high
    9'b11000_1110  // 34 R8 released
  };

  function automatic string rowTag(int r);
    case (r)
      0:                   return "R1";
      1, 2, 3, 8, 9, 10,
      18, 19, 24, 27, 28:  return "R2";
      4, 5, 31:            return "R3";
      12, 30:              return "R4";
      6, 11, 13:           return "R5";
      20, 21:              return "R6";
      22:                  return "R7";
      7, 23, 34:           return "R8";
      14, 15, 16, 17,
      25, 26:              return "R9";
      default:             return "R10";
    endcase
  endfunction

  task automatic checkOut(string tag, logic [3:0] expv);
    logic [3:0] act;
    act = {devselN, trdyN, stopN, xferStrobe};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {devselN,trdyN,stopN,xfer} actual %b expected %b at %0t",
               tag, act, expv, $time);
    end
  endtask

  initial begin
    #5;
    checkOut("R1", 4'b1110); // in reset
    repeat (2) @(negedge clk);
    checkOut("R1", 4'b1110);
    rstN = 1'b1;

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      {frameN, irdyN, addrHit, localReady, localStop} = VEC[r][8:4];
      #1;
      checkOut(rowTag(r), VEC[r][3:0]);
    end

    // Directed R2/R1: reach the data phase, then reset asynchronously
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; addrHit = 1'b1; localReady = 1'b1; localStop = 1'b0;
    @(negedge clk);
    addrHit = 1'b0;
    @(negedge clk);
    #1 checkOut("R2", 4'b1110); // one edge after address phase: not yet
    @(negedge clk);
    #1 checkOut("R2", 4'b0010); // DECODE_LAT edges after address phase
    rstN = 1'b0;
    #1 checkOut("R1", 4'b1110); // asynchronous release
    frameN = 1'b1; irdyN = 1'b1; localReady = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1 checkOut("R1", 4'b1110);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule